// File: doc/BRIEF.md
# Bidirectional Column Sampling-Strobe Sequencer

This block produces the sampling strobes for a column driver of 300 outputs, arranged as 100 groups of three colour columns. A start pulse arriving on one of two chain pins launches a scan. The scan walks through the groups one after the other. Each group either fires its three strobes together or fires them one at a time on three staggered clock phases. When the last group is reached, the block raises a chain output so that the next driver in a row of drivers begins its own scan on the very edge at which this one finishes.

The block runs on a single system clock. The three phase clocks arrive as one-cycle enables, `ph_en[0]` to `ph_en[2]`, and each enable marks the rising edge of its phase. A direction input reverses the order of the walk. It also swaps which chain pin is the input and which is the output.

The control path is one state machine, with states `ST_IDLE`, `ST_GANG`, `ST_SEQ_A`, `ST_SEQ_B` and `ST_SEQ_C`, plus a group counter.
- The transition *launch* takes `ST_IDLE` to `ST_GANG` when the mode is gang, or to `ST_SEQ_A` when the mode is sequential. It happens on a phase-1 enable while the active chain input is high. It clears the counter and latches the direction.
- In gang mode, *gang-step* keeps the machine in `ST_GANG` and advances the counter on each phase-1 enable. *Gang-finish* returns it to `ST_IDLE` on the phase-1 enable that arrives while the last group is active.
- In sequential mode, *slot-2* (`ST_SEQ_A`→`ST_SEQ_B`, on phase 2) and *slot-3* (`ST_SEQ_B`→`ST_SEQ_C`, on phase 3) move through the three columns of a group. *Seq-step* (`ST_SEQ_C`→`ST_SEQ_A`, on phase 1) advances to the next group. *Seq-finish* (`ST_SEQ_C`→`ST_IDLE`, on phase 1) ends the scan after the last group.
- A synchronous reset forces `ST_IDLE` from any state.

Top module: `colscan_strobe_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) clears all 300 strobes and both chain outputs. They read 0 from the following cycle on.
- R2: A scan starts only in idle, on a `ph_en[0]` cycle while the active chain input is high. The first strobe is visible in the cycle after that edge. A `ph_en[1]` or `ph_en[2]` cycle never starts a scan.
- R3: With `scan_fwd`=1, `chain_r_in` is the start input. The groups are visited in the order 0,1,…,99, where group g owns strobe bits 3g, 3g+1 and 3g+2. The chain output is `chain_l_out`, and `chain_r_out` stays 0. A pulse on `chain_l_in` starts nothing.
- R4: With `scan_fwd`=0, `chain_l_in` is the start input. The groups are visited 99 down to 0. The chain output is `chain_r_out`, and `chain_l_out` stays 0. A pulse on `chain_r_in` starts nothing.
- R5: With `gang_mode`=1 (gang mode), a group drives all three of its strobe bits high together. Only `ph_en[0]` advances the scan, and `ph_en[1]` and `ph_en[2]` leave the strobes unchanged.
- R6: With `gang_mode`=0 (sequential mode), exactly one strobe bit is high. In forward scans, phases 1, 2 and 3 fire bits 3g, 3g+1 and 3g+2. In reverse scans they fire 3g+2, 3g+1 and 3g.
- R7: In sequential mode, a phase enable other than the next one expected (phase 2 after phase 1, phase 3 after phase 2, phase 1 after phase 3) leaves the strobes unchanged.
- R8: Any `gang_mode` value other than a solid 1, including an undriven input, selects sequential mode.
- R9: If the start input stays high past the launching edge and across the next phase-1 edge, the first group still fires at the launching edge. The scan moves on to the second group, with no restart and no extra strobe.
- R10: The chain output is high for exactly as long as the last group is active. It rises with the 100th phase-1 edge of the scan, counting the launch edge, and falls together with the strobes on the edge that ends the scan. The two chain outputs are never high together.
- R11: Changes to `scan_fwd` or `gang_mode`, and pulses on the chain inputs, while a scan is running have no effect on that scan.
- R12: At any time the strobe vector has 0, 1 or 3 bits set. Strobes change only in the cycle after a phase enable or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ph_en | input | 3 | One-cycle enables marking rising edges of phases 1..3 (bit 0 = phase 1) |
| scan_fwd | input | 1 | 1 = forward scan (group 0 first), 0 = reverse |
| gang_mode | input | 1 | 1 = gang (three strobes together); anything else = sequential |
| chain_r_in | input | 1 | Start input for forward scans |
| chain_l_in | input | 1 | Start input for reverse scans |
| chain_r_out | output | 1 | Chain output for reverse scans |
| chain_l_out | output | 1 | Chain output for forward scans |
| strobe | output | 300 | Column sampling strobes; bit 3g+j is column j of group g |

## Verification
Every result is due in the cycle after the rising edge that sees the launching or advancing phase enable. The strobes and chain outputs are decoded from registered state, so there is no further latency. The bench raises each enable for one cycle at a falling edge. It samples the outputs at the next falling edge, once the single register stage has updated and before the following enable. Checks that an input is ignored sample at that same falling edge after the ignored enable and compare against the unchanged expected vector. The chain-output timing is checked on every group of a full scan, against a count of phase-1 edges kept in the bench.

// File: rtl/colscan_pkg.sv
`timescale 1ns/1ps
package colscan_pkg;

    localparam int COLS_PER_GROUP = 3;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_GANG  = 3'd1,
        ST_SEQ_A = 3'd2,
        ST_SEQ_B = 3'd3,
        ST_SEQ_C = 3'd4
    } scan_state_e;

    // Position within a group for the sequential states.
    function automatic logic [1:0] seq_slot(input scan_state_e s);
        case (s)
            ST_SEQ_B: seq_slot = 2'd1;
            ST_SEQ_C: seq_slot = 2'd2;
            default:  seq_slot = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/colscan_ctrl.sv
`timescale 1ns/1ps
module colscan_ctrl
    import colscan_pkg::*;
#(
    parameter int  NUM_GROUPS = 100,
    localparam int IDX_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       ph_en,
    input  logic             start_hit,
    input  logic             dir_live,
    input  logic             gang_live,
    output scan_state_e      state_q,
    output logic [IDX_W-1:0] stage_q,
    output logic             dir_q,
    output logic             last_stage
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_GROUPS - 1);

    scan_state_e      state_d;
    logic [IDX_W-1:0] stage_d;
    logic             dir_d;
    logic             at_last;

    assign at_last    = (stage_q == LAST_IDX);
    assign last_stage = (state_q != ST_IDLE) && at_last;

    // Next-state process
    always_comb begin
        state_d = state_q;
        stage_d = stage_q;
        dir_d   = dir_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ph_en[0] && start_hit) begin
                    state_d = gang_live ? ST_GANG : ST_SEQ_A;
                    stage_d = '0;
                    dir_d   = dir_live;
                end
            end
            ST_GANG: begin
                if (ph_en[0]) begin
                    if (at_last) state_d = ST_IDLE;
                    else         stage_d = stage_q + 1'b1;
                end
            end
            ST_SEQ_A: begin
                if (ph_en[1]) state_d = ST_SEQ_B;
            end
            ST_SEQ_B: begin
                if (ph_en[2]) state_d = ST_SEQ_C;
            end
            ST_SEQ_C: begin
                if (ph_en[0]) begin
                    if (at_last) begin
                        state_d = ST_IDLE;
                    end else begin
                        state_d = ST_SEQ_A;
                        stage_d = stage_q + 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            stage_q <= '0;
            dir_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            stage_q <= stage_d;
            dir_q   <= dir_d;
        end
    end

endmodule

// File: rtl/colscan_decode.sv
`timescale 1ns/1ps
module colscan_decode
    import colscan_pkg::*;
#(
    parameter int  NUM_GROUPS = 100,
    localparam int IDX_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
    localparam int NUM_COLS   = COLS_PER_GROUP * NUM_GROUPS
) (
    input  scan_state_e      state_q,
    input  logic [IDX_W-1:0] stage_q,
    input  logic             dir_q,
    output logic [NUM_COLS-1:0] strobe
);

    logic       gang_on;
    logic       seq_on;
    logic [1:0] slot;

    assign gang_on = (state_q == ST_GANG);
    assign seq_on  = (state_q == ST_SEQ_A) || (state_q == ST_SEQ_B) ||
                     (state_q == ST_SEQ_C);
    assign slot    = seq_slot(state_q);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic grp_hit;
        assign grp_hit = dir_q ? (stage_q == IDX_W'(g))
                               : (stage_q == IDX_W'(NUM_GROUPS - 1 - g));
        for (genvar j = 0; j < COLS_PER_GROUP; j++) begin : g_col
            localparam logic [1:0] FWD_SLOT = 2'(j);
            localparam logic [1:0] REV_SLOT = 2'(COLS_PER_GROUP - 1 - j);
            assign strobe[g*COLS_PER_GROUP + j] =
                grp_hit && (gang_on ||
                            (seq_on && (slot == (dir_q ? FWD_SLOT : REV_SLOT))));
        end
    end

endmodule

// File: rtl/colscan_cascade.sv
`timescale 1ns/1ps
module colscan_cascade (
    input  logic chain_r_in,
    input  logic chain_l_in,
    input  logic dir_live,
    input  logic dir_q,
    input  logic last_stage,
    output logic start_hit,
    output logic chain_r_out,
    output logic chain_l_out
);

    // The start input follows the live direction (only used while idle);
    // the chain output follows the direction latched at launch.
    assign start_hit   = dir_live ? chain_r_in : chain_l_in;
    assign chain_l_out = last_stage &&  dir_q;
    assign chain_r_out = last_stage && !dir_q;

endmodule

// File: rtl/colscan_strobe_gen.sv
`timescale 1ns/1ps
module colscan_strobe_gen
    import colscan_pkg::*;
#(
    parameter int  NUM_GROUPS = 100,
    localparam int IDX_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
    localparam int NUM_COLS   = COLS_PER_GROUP * NUM_GROUPS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          ph_en,
    input  logic                scan_fwd,
    input  logic                gang_mode,
    input  logic                chain_r_in,
    input  logic                chain_l_in,
    output logic                chain_r_out,
    output logic                chain_l_out,
    output logic [NUM_COLS-1:0] strobe
);

    scan_state_e      state_q;
    logic [IDX_W-1:0] stage_q;
    logic             dir_q;
    logic             last_stage;
    logic             start_hit;
    logic             gang_solid;

    // Weak pull-down model: only a solid 1 selects gang mode.
    assign gang_solid = (gang_mode === 1'b1);

    colscan_ctrl #(.NUM_GROUPS(NUM_GROUPS)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .ph_en      (ph_en),
        .start_hit  (start_hit),
        .dir_live   (scan_fwd),
        .gang_live  (gang_solid),
        .state_q    (state_q),
        .stage_q    (stage_q),
        .dir_q      (dir_q),
        .last_stage (last_stage)
    );

    colscan_decode #(.NUM_GROUPS(NUM_GROUPS)) decode_i (
        .state_q (state_q),
        .stage_q (stage_q),
        .dir_q   (dir_q),
        .strobe  (strobe)
    );

    colscan_cascade cascade_i (
        .chain_r_in  (chain_r_in),
        .chain_l_in  (chain_l_in),
        .dir_live    (scan_fwd),
        .dir_q       (dir_q),
        .last_stage  (last_stage),
        .start_hit   (start_hit),
        .chain_r_out (chain_r_out),
        .chain_l_out (chain_l_out)
    );

endmodule

// File: rtl/colscan_strobe_gen_chk.sv
`timescale 1ns/1ps
module colscan_strobe_gen_chk #(
    parameter int  NUM_GROUPS = 100,
    localparam int NUM_COLS   = 3 * NUM_GROUPS
) (
    input logic                clk,
    input logic                rst,
    input logic [2:0]          ph_en,
    input logic                chain_r_out,
    input logic                chain_l_out,
    input logic [NUM_COLS-1:0] strobe
);

    // R1: reset clears every output
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> ((strobe == '0) && !chain_r_out && !chain_l_out));

    // R12: a single group at most (0, 1 or 3 bits)
    p_group_width_r12: assert property (@(posedge clk) disable iff (rst)
        (($countones(strobe) == 0) || ($countones(strobe) == 1) ||
         ($countones(strobe) == 3)));

    // R12: no phase enable, no strobe change
    p_hold_no_phase_r12: assert property (@(posedge clk) disable iff (rst)
        !(|ph_en) |=> $stable(strobe));

    // R10: chain outputs mutually exclusive
    p_chain_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(chain_r_out && chain_l_out));

    // R3: forward chain output only while the top group fires
    p_chain_tail_r3: assert property (@(posedge clk) disable iff (rst)
        chain_l_out |-> (|strobe[NUM_COLS-1 -: 3]));

    // R4: reverse chain output only while group 0 fires
    p_chain_head_r4: assert property (@(posedge clk) disable iff (rst)
        chain_r_out |-> (|strobe[2:0]));

endmodule

bind colscan_strobe_gen colscan_strobe_gen_chk #(.NUM_GROUPS(NUM_GROUPS)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .ph_en       (ph_en),
    .chain_r_out (chain_r_out),
    .chain_l_out (chain_l_out),
    .strobe      (strobe)
);

// File: tb/colscan_strobe_gen_tb_top.sv
`timescale 1ns/1ps
module colscan_strobe_gen_tb_top;

    localparam int NG   = 100;
    localparam int NCOL = 3 * NG;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst;
    logic [2:0]      ph_en;
    logic            scan_fwd;
    logic            gang_mode;
    logic            chain_r_in;
    logic            chain_l_in;
    logic            chain_r_out;
    logic            chain_l_out;
    logic [NCOL-1:0] strobe;

    int checks = 0;
    int errors = 0;

    colscan_strobe_gen #(.NUM_GROUPS(NG)) dut_i (
        .clk(clk), .rst(rst), .ph_en(ph_en), .scan_fwd(scan_fwd),
        .gang_mode(gang_mode), .chain_r_in(chain_r_in), .chain_l_in(chain_l_in),
        .chain_r_out(chain_r_out), .chain_l_out(chain_l_out), .strobe(strobe)
    );

    function automatic logic [NCOL-1:0] exp_vec(input int k, input int s,
                                                 input bit gang, input bit fwd);
        logic [NCOL-1:0] v = '0;
        int g = fwd ? k : NG - 1 - k;
        if (gang) begin
            v[3*g] = 1'b1; v[3*g+1] = 1'b1; v[3*g+2] = 1'b1;
        end else begin
            v[fwd ? 3*g + s : 3*g + 2 - s] = 1'b1;
        end
        return v;
    endfunction

    task automatic chk_vec(input string req, input logic [NCOL-1:0] exp);
        checks++;
        if (strobe !== exp) begin
            errors++;
            $display("FAIL %s: strobe actual %h expected %h", req, strobe, exp);
        end
    endtask

    task automatic chk_bit(input string req, input string what,
                           input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: %s actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Raise an enable for one cycle; returns at the falling edge after the
    // rising edge that saw it, where the updated outputs are sampled.
    task automatic step(input logic [2:0] en);
        @(negedge clk);
        ph_en = en;
        @(negedge clk);
        ph_en = 3'b000;
    endtask

    task automatic do_reset();
        rst = 1'b1; ph_en = 3'b000; chain_r_in = 1'b0; chain_l_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic launch(input bit fwd, input bit keep);
        scan_fwd = fwd;
        if (fwd) chain_r_in = 1'b1; else chain_l_in = 1'b1;
        step(3'b001);
        if (!keep) begin chain_r_in = 1'b0; chain_l_in = 1'b0; end
    endtask

    // Walks a scan that was just launched to its end, checking every group.
    task automatic walk(input bit fwd, input bit gang, input bit meddle,
                        input string req);
        for (int k = 0; k < NG; k++) begin
            if (k > 0) step(3'b001);
            if (gang) begin
                chk_vec({req, " R5 gang group"}, exp_vec(k, 0, 1, fwd));
                if (k == 0) begin
                    step(3'b010); step(3'b100);
                    chk_vec("R5 phases 2/3 ignored", exp_vec(k, 0, 1, fwd));
                end
            end else begin
                chk_vec({req, " R6 slot1"}, exp_vec(k, 0, 0, fwd));
                if (k == 0) begin
                    step(3'b100);
                    chk_vec("R7 phase3 before phase2 ignored", exp_vec(k, 0, 0, fwd));
                end
                step(3'b010);
                chk_vec({req, " R6 slot2"}, exp_vec(k, 1, 0, fwd));
                step(3'b100);
                chk_vec({req, " R6 slot3"}, exp_vec(k, 2, 0, fwd));
                if (k == 0) begin
                    step(3'b010);
                    chk_vec("R7 phase2 after phase3 ignored", exp_vec(k, 2, 0, fwd));
                end
            end
            chk_bit("R10", "chain out", fwd ? chain_l_out : chain_r_out, k == NG - 1);
            chk_bit(fwd ? "R3" : "R4", "idle-side chain out",
                    fwd ? chain_r_out : chain_l_out, 1'b0);
            if (meddle && k == NG / 2) begin
                scan_fwd = ~fwd; gang_mode = ~gang;
                chain_r_in = 1'b1; chain_l_in = 1'b1;
                step(3'b001);
                chain_r_in = 1'b0; chain_l_in = 1'b0;
                k++;
                chk_vec("R11 mid-scan changes ignored", exp_vec(k, 0, gang, fwd));
                if (!gang) begin
                    step(3'b010); step(3'b100);
                    chk_vec("R11 sequence kept", exp_vec(k, 2, 0, fwd));
                end
            end
        end
        step(3'b001);
        chk_vec("R10 scan end clears strobes", '0);
        chk_bit("R10", "chain out after end", chain_r_out | chain_l_out, 1'b0);
    endtask

    task automatic t_reset();
        do_reset();
        chk_vec("R1 reset strobes", '0);
        chk_bit("R1", "chain outputs", chain_r_out | chain_l_out, 1'b0);
        gang_mode = 1'b1;
        launch(1, 0);
        step(3'b001);
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        chk_vec("R1 reset mid-scan", '0);
    endtask

    task automatic t_no_start();
        do_reset();
        gang_mode = 1'b1; scan_fwd = 1'b1;
        chain_r_in = 1'b1;
        step(3'b010); step(3'b100);
        chain_r_in = 1'b0;
        chk_vec("R2 phase 2/3 never launch", '0);
        chain_l_in = 1'b1; step(3'b001); chain_l_in = 1'b0;
        chk_vec("R3 wrong pin in forward", '0);
        scan_fwd = 1'b0;
        chain_r_in = 1'b1; step(3'b001); chain_r_in = 1'b0;
        chk_vec("R4 wrong pin in reverse", '0);
    endtask

    task automatic t_gang_fwd();
        do_reset(); gang_mode = 1'b1;
        launch(1, 0);
        walk(1, 1, 0, "R2 R3");
    endtask

    task automatic t_gang_rev();
        do_reset(); gang_mode = 1'b1;
        launch(0, 0);
        walk(0, 1, 1, "R4");
    endtask

    task automatic t_seq_fwd();
        do_reset(); gang_mode = 1'b0;
        launch(1, 0);
        walk(1, 0, 0, "R3");
    endtask

    task automatic t_seq_rev();
        do_reset(); gang_mode = 1'b0;
        launch(0, 0);
        walk(0, 0, 1, "R4");
    endtask

    task automatic t_long_start();
        do_reset(); gang_mode = 1'b1;
        launch(1, 1);
        chk_vec("R9 first group on time", exp_vec(0, 0, 1, 1));
        step(3'b001);
        chain_r_in = 1'b0;
        chk_vec("R9 no restart, second group", exp_vec(1, 0, 1, 1));
        step(3'b001);
        chk_vec("R9 third group", exp_vec(2, 0, 1, 1));
    endtask

    task automatic t_mode_float();
        do_reset(); gang_mode = 1'bz;
        launch(1, 0);
        chk_vec("R8 undriven mode is sequential", exp_vec(0, 0, 0, 1));
        step(3'b010);
        chk_vec("R8 second slot", exp_vec(0, 1, 0, 1));
    endtask

    initial begin
        rst = 1'b1; ph_en = 3'b000; scan_fwd = 1'b1; gang_mode = 1'b0;
        chain_r_in = 1'b0; chain_l_in = 1'b0;
        t_reset();
        t_no_start();
        t_gang_fwd();
        t_gang_rev();
        t_seq_fwd();
        t_seq_rev();
        t_long_start();
        t_mode_float();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_900_000;
        checks++; errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule